// File: doc/BRIEF.md
# Synchronous Burst Flash Read Controller

This block reads a synchronous burst flash device on behalf of a single host. It produces the flash clock at half the system clock rate, together with the chip select, address-valid strobe, output enable and write enable. The first word of a burst arrives after a programmed address-valid latency. After that the block captures one word on every flash clock for as long as the host keeps asking for the next sequential address.

The host issues one word request at a time: it holds `reqValid` high with `reqAddr` until `reqReady` and `rspValid` pulse together with the captured word. If no request is pending when a flash cycle is due, the block suspends the burst. It drops chip select and output enable and releases the address and data lines, so other masters can use the shared bus. A mode input chooses what happens next. In resume mode, a request for the next sequential word reopens the burst with output enable only and returns data after the output-enable latency. In restart mode, every request after a suspension begins a fresh burst with a new address phase. In both modes, a non-sequential request always begins a fresh burst, whether the burst is streaming or suspended.

When address and data share one bus, the low address bits are driven on the data lines only while the address-valid strobe is active.

Top module: `burst_flash_reader`

## Requirements
- R1: In reset, and in the cycle after reset is released, the block is idle. `fCsN`, `fAvdN`, `fOeN` and `fWeN` are all 1, `fAddrOe`, `fDataOe`, `rspValid` and `reqReady` are all 0, and `fClk` is 0.
- R2: Each new burst drives `fAvdN` low for exactly one flash clock period, which is two system cycles. During that period `fCsN` is 0, `fAddrOe` is 1, `fDataOe` is 1 and `fDout` equals `reqAddr[15:0]`. `fDataOe` is 0 at every other time.
- R3: With an address-valid latency field of F (4 bits), the first word of a new burst returns `rspValid` after F+1 rising edges of `fClk`, counted after the rising edge that sees `fAvdN` low.
- R4: While streaming, a request for the previous address plus one returns on the next flash clock, exactly one `fClk` rising edge after the previous response. `rspData` equals the value on `fDin` in that cycle, and `reqReady` pulses with `rspValid`.
- R5: When a flash cycle passes with `reqValid` low during streaming, the burst is suspended. `fOeN` and `fCsN` return to 1, and `fAddrOe` and `fDataOe` return to 0.
- R6: In resume mode (`resumeMode`=1), a sequential request after a suspension reasserts `fOeN` low without any `fAvdN` pulse. Data returns after `oeLat` rising edges of `fClk`, counted after the first rising edge that sees `fOeN` low.
- R7: In resume mode, a non-sequential request after a suspension starts a new burst with an `fAvdN` pulse and the R3 latency.
- R8: In restart mode (`resumeMode`=0), even a sequential request after a suspension starts a new burst with an `fAvdN` pulse and the R3 latency.
- R9: A non-sequential request that arrives during streaming starts a new burst with an `fAvdN` pulse and the R3 latency.
- R10: `fWeN` stays 1 at all times.
- R11: After reset, `fClk` changes value on every system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| resumeMode | input | 1 | 1 keeps a suspended burst open for resume, 0 restarts after suspension |
| avlField | input | 4 | Address-valid latency, encoded as flash cycles minus one |
| oeLat | input | 4 | Output-enable latency in flash cycles for a resume (0 is treated as 1) |
| reqValid | input | 1 | Host holds a word request |
| reqReady | output | 1 | Request completed this cycle |
| reqAddr | input | 25 | Word address of the request |
| rspValid | output | 1 | Read data valid, one-cycle pulse |
| rspData | output | 16 | Captured read word |
| fClk | output | 1 | Flash clock, half the system rate |
| fCsN | output | 1 | Flash chip select, active low |
| fAvdN | output | 1 | Address-valid strobe, active low |
| fOeN | output | 1 | Output enable, active low |
| fWeN | output | 1 | Write enable, active low, held inactive |
| fAddr | output | 25 | Flash address lines |
| fAddrOe | output | 1 | Drive enable for the address lines |
| fDin | input | 16 | Data from the flash |
| fDout | output | 16 | Value driven on the shared data lines (address phase) |
| fDataOe | output | 1 | Drive enable for the data lines |

## Verification
Two decisions can fall on the same flash cycle. One is whether to capture a word or to suspend the burst. The other is whether an arriving request continues the open burst or opens a new one. The bench provokes the first by withdrawing the request just before a streaming cycle, then offering the next sequential address later, in both modes. It provokes the second by offering a non-sequential address in the cycle that would otherwise have been captured. In each case it judges the outcome at the pins by whether an address-valid pulse appears and by the number of flash clock edges before the data returns.

// File: rtl/bfr_pkg.sv
package bfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_STREAM,
    ST_RESUME
  } bfrState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadBase;   // latch request address as new burst base
    logic advance;    // capture a word and step the expected address
    logic addrPhase;  // address-valid period in progress
    logic busOwn;     // controller owns the shared lines
  } bfrStrobe_t;

endpackage

// File: rtl/bfr_clkgen.sv
module bfr_clkgen (
  input  logic clk,
  input  logic rstN,
  output logic fClk,
  output logic tick
);

  always_ff @(posedge clk) begin
    if (!rstN) fClk <= 1'b0;
    else       fClk <= ~fClk;
  end

  // Control advances on the edge where the flash clock falls
  assign tick = fClk;

  a_r11_fclk_toggles: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (fClk != $past(fClk)));

endmodule

// File: rtl/bfr_ctrl.sv
module bfr_ctrl
  import bfr_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             reqValid,
  input  logic             seqHit,
  input  logic             resumeMode,
  input  logic [LAT_W-1:0] avlField,
  input  logic [LAT_W-1:0] oeLat,
  output bfrStrobe_t       strb,
  output logic             csN,
  output logic             avdN,
  output logic             oeN,
  output logic             weN
);

  bfrState_e        state, nxt;
  logic [LAT_W-1:0] cnt, cntNxt;
  logic             burstOpen, openNxt;
  logic [LAT_W-1:0] oeLoad;

  assign oeLoad = (oeLat == '0) ? '0 : oeLat - LAT_W'(1);

  always_comb begin
    nxt            = state;
    cntNxt         = cnt;
    openNxt        = burstOpen;
    strb           = '0;
    strb.addrPhase = (state == ST_ADDR);
    strb.busOwn    = (state != ST_IDLE);
    if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (resumeMode && burstOpen && seqHit) begin
              nxt    = ST_RESUME;
              cntNxt = oeLoad;
            end else begin
              nxt           = ST_ADDR;
              strb.loadBase = 1'b1;
              openNxt       = 1'b0;
            end
          end
        end
        ST_ADDR: begin
          if (avlField == '0) begin
            nxt = ST_STREAM;
          end else begin
            nxt    = ST_WAIT;
            cntNxt = avlField - LAT_W'(1);
          end
        end
        ST_WAIT, ST_RESUME: begin
          if (cnt == '0) nxt = ST_STREAM;
          else           cntNxt = cnt - LAT_W'(1);
        end
        ST_STREAM: begin
          if (!reqValid) begin
            nxt     = ST_IDLE;
            openNxt = resumeMode;
          end else if (seqHit) begin
            strb.advance = 1'b1;
          end else begin
            nxt           = ST_ADDR;
            strb.loadBase = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      burstOpen <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= cntNxt;
      burstOpen <= openNxt;
    end
  end

  assign csN  = (state == ST_IDLE);
  assign avdN = (state != ST_ADDR);
  assign oeN  = !((state == ST_WAIT) || (state == ST_STREAM) || (state == ST_RESUME));
  assign weN  = 1'b1;

  // R2: the address-valid strobe spans exactly two system cycles
  a_r2_avd_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!avdN && $past(avdN)) |=> !avdN);
  a_r2_avd_ends: assert property (@(posedge clk) disable iff (!rstN)
    (!avdN && !$past(avdN)) |=> avdN);

  // R6: a resume is entered only for a sequential request in resume mode
  a_r6_resume_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESUME && $past(state) == ST_IDLE) |-> $past(seqHit && resumeMode));

  // R9: leaving the stream for a new address phase needs a non-sequential request
  a_r9_stream_restart: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_STREAM && state == ST_ADDR) |-> $past(reqValid && !seqHit));

endmodule

// File: rtl/bfr_dpath.sv
module bfr_dpath
  import bfr_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16,
  parameter bit MUX_AD = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfrStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] fDin,
  output logic              seqHit,
  output logic [ADDR_W-1:0] fAddr,
  output logic              fAddrOe,
  output logic [DATA_W-1:0] fDout,
  output logic              fDataOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              reqReady
);

  localparam int MUX_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

  logic [ADDR_W-1:0] nextAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.advance;
      if (strb.loadBase)     nextAddr <= reqAddr;
      else if (strb.advance) nextAddr <= nextAddr + ADDR_W'(1);
      if (strb.advance)      rspData  <= fDin;
    end
  end

  assign seqHit   = (reqAddr == nextAddr);
  assign reqReady = rspValid;
  assign fAddr    = nextAddr;
  assign fAddrOe  = strb.busOwn;

  generate
    if (MUX_AD) begin : g_shared
      assign fDout   = DATA_W'(nextAddr[MUX_W-1:0]);
      assign fDataOe = strb.addrPhase;
    end else begin : g_split
      assign fDout   = '0;
      assign fDataOe = 1'b0;
    end
  endgenerate

  // R4: at most one word per flash cycle
  a_r4_one_word_per_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2: data lines carry the address only while the bus is owned
  a_r2_data_drive_owned: assert property (@(posedge clk) disable iff (!rstN)
    fDataOe |-> fAddrOe);

endmodule

// File: rtl/burst_flash_reader.sv
module burst_flash_reader
  import bfr_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4,
  parameter bit MUX_AD = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resumeMode,
  input  logic [LAT_W-1:0]  avlField,
  input  logic [LAT_W-1:0]  oeLat,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              fClk,
  output logic              fCsN,
  output logic              fAvdN,
  output logic              fOeN,
  output logic              fWeN,
  output logic [ADDR_W-1:0] fAddr,
  output logic              fAddrOe,
  input  logic [DATA_W-1:0] fDin,
  output logic [DATA_W-1:0] fDout,
  output logic              fDataOe
);

  logic       tick;
  logic       seqHit;
  bfrStrobe_t strb;

  bfr_clkgen u_clk (
    .clk  (clk),
    .rstN (rstN),
    .fClk (fClk),
    .tick (tick)
  );

  bfr_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .reqValid   (reqValid),
    .seqHit     (seqHit),
    .resumeMode (resumeMode),
    .avlField   (avlField),
    .oeLat      (oeLat),
    .strb       (strb),
    .csN        (fCsN),
    .avdN       (fAvdN),
    .oeN        (fOeN),
    .weN        (fWeN)
  );

  bfr_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MUX_AD(MUX_AD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .fDin     (fDin),
    .seqHit   (seqHit),
    .fAddr    (fAddr),
    .fAddrOe  (fAddrOe),
    .fDout    (fDout),
    .fDataOe  (fDataOe),
    .rspValid (rspValid),
    .rspData  (rspData),
    .reqReady (reqReady)
  );

endmodule

// File: tb/sim_burst_flash_reader.sv
`timescale 1ns/1ps
module sim_burst_flash_reader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resumeMode = 1'b0;
  logic [3:0]  avlField = 4'd3;
  logic [3:0]  oeLat = 4'd2;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [24:0] reqAddr = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        fClk, fCsN, fAvdN, fOeN, fWeN, fAddrOe, fDataOe;
  logic [24:0] fAddr;
  logic [15:0] fDin, fDout;

  always #4 clk = ~clk;

  burst_flash_reader u0 (
    .clk(clk), .rstN(rstN), .resumeMode(resumeMode), .avlField(avlField),
    .oeLat(oeLat), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspData(rspData), .fClk(fClk), .fCsN(fCsN),
    .fAvdN(fAvdN), .fOeN(fOeN), .fWeN(fWeN), .fAddr(fAddr), .fAddrOe(fAddrOe),
    .fDin(fDin), .fDout(fDout), .fDataOe(fDataOe)
  );

  function automatic logic [15:0] pat(input logic [24:0] a);
    return a[15:0] ^ {7'h35, a[24:16]} ^ 16'hC35A;
  endfunction

  assign fDin = pat(reqAddr);

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input string what, input logic ok,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash clock edge bookkeeping
  int riseCnt = 0, avdRise = 0, oeRise = 0;
  logic oeWasHigh = 1'b1;
  always @(posedge fClk) begin
    riseCnt++;
    if (!fAvdN) avdRise = riseCnt;
    if (!fOeN && oeWasHigh) oeRise = riseCnt;
    oeWasHigh = fOeN;
  end

  // pin monitors
  int avdRun = 0, avdPulses = 0, avdBad = 0, weBad = 0, clkBad = 0;
  logic prevFClk = 1'b0, prevRst = 1'b0;
  always @(negedge clk) begin
    if (fWeN !== 1'b1) weBad++;
    if (rstN && prevRst && fClk == prevFClk) clkBad++;
    prevFClk = fClk;
    prevRst  = rstN;
    if (rstN) begin
      if (!fAvdN) begin
        avdRun++;
        if (fCsN || !fAddrOe || !fDataOe || fDout != reqAddr[15:0]) avdBad++;
      end else begin
        if (fDataOe) avdBad++;
        if (avdRun != 0) begin
          if (avdRun != 2) avdBad++;
          avdPulses++;
          avdRun = 0;
        end
      end
    end else begin
      avdRun = 0;
    end
  end

  task automatic xfer(input logic [24:0] a, output int rc, output logic [15:0] d);
    int guard;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    guard    = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!rspValid && guard < 200);
    chk("R4", "response arrives", rspValid, guard, 0);
    chk("R4", "ready with data", reqReady === 1'b1, reqReady, 1);
    rc = riseCnt;
    d  = rspData;
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkReleased(input string req);
    chk(req, "oe released", fOeN == 1'b1, fOeN, 1);
    chk(req, "cs released", fCsN == 1'b1, fCsN, 1);
    chk(req, "addr drive off", fAddrOe == 1'b0, fAddrOe, 0);
    chk(req, "data drive off", fDataOe == 1'b0, fDataOe, 0);
  endtask

  typedef struct packed {
    logic        mode;
    logic [3:0]  avl;
    logic [3:0]  oel;
    logic [24:0] base;
    logic [3:0]  words;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 4'd3,  4'd2, 25'h0000100, 4'd4},
    '{1'b0, 4'd0,  4'd1, 25'h1ABCDE0, 4'd3},
    '{1'b1, 4'd7,  4'd4, 25'h0FFFFFE, 4'd5},
    '{1'b0, 4'd15, 4'd2, 25'h1FFFFFD, 4'd2},
    '{1'b1, 4'd1,  4'd3, 25'h0012340, 4'd6}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int rc, prev, p;
    logic [15:0] d;
    logic [24:0] a;

    repeat (4) @(negedge clk);
    // R1: reset state, checked while in reset and just after release
    chk("R1", "cs in reset", fCsN == 1'b1, fCsN, 1);
    chk("R1", "fclk in reset", fClk == 1'b0, fClk, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "cs idle", fCsN == 1'b1, fCsN, 1);
    chk("R1", "avd idle", fAvdN == 1'b1, fAvdN, 1);
    chk("R1", "oe idle", fOeN == 1'b1, fOeN, 1);
    chk("R1", "we idle", fWeN == 1'b1, fWeN, 1);
    chk("R1", "drives idle", {fAddrOe, fDataOe} == 2'b00, {fAddrOe, fDataOe}, 0);
    chk("R1", "no response", {rspValid, reqReady} == 2'b00, {rspValid, reqReady}, 0);

    // Vector table: fresh bursts of sequential words, then suspension
    foreach (VECS[i]) begin
      resumeMode = VECS[i].mode;
      avlField   = VECS[i].avl;
      oeLat      = VECS[i].oel;
      p = avdPulses;
      for (int w = 0; w < int'(VECS[i].words); w++) begin
        a = VECS[i].base + 25'(w);
        xfer(a, rc, d);
        chk("R4", "data", d == pat(a), d, pat(a));
        if (w == 0) begin
          chk("R3", "first latency", rc - avdRise == int'(VECS[i].avl) + 1,
              rc - avdRise, int'(VECS[i].avl) + 1);
          chk("R2", "one avd pulse", avdPulses == p + 1, avdPulses, p + 1);
        end else begin
          chk("R4", "stream spacing", rc - prev == 1, rc - prev, 1);
        end
        prev = rc;
      end
      idle(6);
      chkReleased("R5");
    end

    // R6: resume mode, sequential request after suspension
    resumeMode = 1'b1; avlField = 4'd3; oeLat = 4'd2;
    xfer(25'h0000400, rc, d);
    xfer(25'h0000401, rc, d);
    idle(6);
    chkReleased("R5");
    p = avdPulses;
    xfer(25'h0000402, rc, d);
    chk("R6", "no avd on resume", avdPulses == p, avdPulses, p);
    chk("R6", "oe latency 2", rc - oeRise == 2, rc - oeRise, 2);
    chk("R6", "resume data", d == pat(25'h0000402), d, pat(25'h0000402));
    idle(6);
    oeLat = 4'd1;
    xfer(25'h0000403, rc, d);
    chk("R6", "no avd on resume", avdPulses == p, avdPulses, p);
    chk("R6", "oe latency 1", rc - oeRise == 1, rc - oeRise, 1);

    // R7: resume mode, non-sequential request after suspension
    idle(6);
    p = avdPulses;
    xfer(25'h0002000, rc, d);
    chk("R7", "new avd", avdPulses == p + 1, avdPulses, p + 1);
    chk("R7", "full latency", rc - avdRise == 4, rc - avdRise, 4);
    chk("R7", "data", d == pat(25'h0002000), d, pat(25'h0002000));

    // R8: restart mode, sequential request after suspension
    idle(6);
    resumeMode = 1'b0; avlField = 4'd5; oeLat = 4'd2;
    xfer(25'h0003000, rc, d);
    xfer(25'h0003001, rc, d);
    idle(6);
    p = avdPulses;
    xfer(25'h0003002, rc, d);
    chk("R8", "new avd", avdPulses == p + 1, avdPulses, p + 1);
    chk("R8", "full latency", rc - avdRise == 6, rc - avdRise, 6);
    chk("R8", "data", d == pat(25'h0003002), d, pat(25'h0003002));

    // R9: non-sequential request in the cycle that would have streamed
    idle(6);
    resumeMode = 1'b1; avlField = 4'd2;
    xfer(25'h0004000, rc, d);
    p = avdPulses;
    xfer(25'h0005555, rc, d);
    chk("R9", "new avd", avdPulses == p + 1, avdPulses, p + 1);
    chk("R9", "full latency", rc - avdRise == 3, rc - avdRise, 3);
    chk("R9", "data", d == pat(25'h0005555), d, pat(25'h0005555));

    // R1: reset during the latency wait returns to idle
    idle(6);
    avlField = 4'd9;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = 25'h0006000;
    idle(8);
    chk("R1", "oe active before reset", fOeN == 1'b0, fOeN, 0);
    rstN = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "mid reset cs", fCsN == 1'b1, fCsN, 1);
    chk("R1", "mid reset oe", fOeN == 1'b1, fOeN, 1);
    chk("R1", "mid reset drive", fAddrOe == 1'b0, fAddrOe, 0);
    chk("R1", "mid reset fclk", fClk == 1'b0, fClk, 0);
    rstN = 1'b1;
    idle(4);
    chk("R1", "no stray response", rspValid == 1'b0, rspValid, 0);

    chk("R2", "avd pulse shape", avdBad == 0, avdBad, 0);
    chk("R10", "write enable high", weBad == 0, weBad, 0);
    chk("R11", "flash clock toggles", clkBad == 0, clkBad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule